// File: doc/BRIEF.md
# Load/Store Data Alignment Unit

This unit connects an integer pipeline to a data memory that is addressed by 32-bit words. The pipeline hands over a base register value, a 12-bit signed offset, an access size, a signedness flag and, for stores, the register data. The unit forms the byte address and places the bytes on the right memory lanes, lowest address on the least significant lane. For stores it also generates a byte-enable mask. For loads it collects the returned bytes, moves them down to bit 0, and sign- or zero-extends them to the full register width.

An access whose bytes fall into two neighbouring words is carried out in hardware as two word transactions, and no trap is raised. The unit sends the lower word first and then the next word up. For a load, it joins the two returned words before extension. The memory port is a valid/ready request channel with a separate response strobe. Only one transaction can be outstanding at a time, and the memory returns a response for writes as well as reads. While an access is in progress the unit holds `busy_o` high and refuses new requests. When the access finishes it gives a one-cycle `done_o` pulse, and for a load the result appears on `load_data_o` in that cycle.

Top module: `mem_align_unit`

## Requirements
- R1: The byte address is `req_base_i` plus `req_imm_i` sign-extended from 12 bits. Every memory request carries a word-aligned address (bits 1:0 zero). The first request of an access uses the byte address with its two low bits cleared.
- R2: Lanes are little-endian. Byte n of the access goes to byte address ea+n, and that byte address maps to lane (ea+n) mod 4, meaning bits 8k+7:8k of the memory word for lane k. This holds for both store data and load data.
- R3: With `req_unsigned_i`=0, a byte load (size code 0) or halfword load (size code 1) returns its value sign-extended to 32 bits.
- R4: With `req_unsigned_i`=1, byte and halfword loads are zero-extended. A word load (size code 2) returns all 32 bits whatever the flag says.
- R5: In a store, `mem_we_o`=1 and bit k of `mem_be_o` is set exactly when lane k holds a byte of the access. Bytes outside the access remain unchanged in memory.
- R6: When (ea mod 4) plus the access size in bytes is greater than 4, the access becomes two requests. The first goes to the lower word and the second to that address plus 4. Each request enables only its own lanes. A load joins both words before extension.
- R7: Any other access produces exactly one memory request.
- R8: `busy_o` rises in the cycle after a request is accepted (`req_valid_i` and `req_ready_o` both high at a clock edge). It falls in the cycle after the final response. `req_ready_o` is the inverse of `busy_o`, so a request presented while busy is not taken and does not affect the access in progress. Reset clears `busy_o`, `done_o` and `mem_req_o`.
- R9: `done_o` is high for exactly one cycle, the cycle after the final response. In that cycle `busy_o` is low, and for a load `load_data_o` holds the result.
- R10: `mem_req_o` and its address, enables, write flag and data stay unchanged until `mem_gnt_i` is seen. No new request is raised before the response to the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Pipeline presents an access |
| req_ready_o | output | 1 | Unit can take an access |
| req_store_i | input | 1 | 1 for store, 0 for load |
| req_size_i | input | 2 | Size code: 0 byte, 1 halfword, 2 word |
| req_unsigned_i | input | 1 | Zero-extend narrow loads |
| req_base_i | input | 32 | Base register value |
| req_imm_i | input | 12 | Signed offset |
| req_wdata_i | input | 32 | Store data, right-aligned |
| busy_o | output | 1 | Access in progress |
| done_o | output | 1 | One-cycle completion pulse |
| load_data_o | output | 32 | Extended load result |
| mem_req_o | output | 1 | Memory request valid |
| mem_gnt_i | input | 1 | Memory accepts the request |
| mem_addr_o | output | 32 | Word-aligned byte address |
| mem_we_o | output | 1 | Write request |
| mem_be_o | output | 4 | Lane enables |
| mem_wdata_o | output | 32 | Lane-steered write data |
| mem_rvalid_i | input | 1 | Response strobe, for reads and writes |
| mem_rdata_i | input | 32 | Read data, valid with the strobe |

## Verification
The properties assume that the memory raises `mem_rvalid_i` once per granted request, only after the grant and before any later grant. They also assume the pipeline keeps `req_valid_i` low while reset is applied. The bench memory meets this: it grants only when nothing is outstanding, answers after one or two cycles, and throttles grants on a fixed pattern. The pipeline model holds off during reset. To show that requests are refused while busy, it presents junk requests only in cycles when the unit is busy.

// File: rtl/mau_pkg.sv
package mau_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } acc_size_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/mau_agen.sv
module mau_agen #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 12
) (
  input  logic [DATA_W-1:0] base_i,
  input  logic [IMM_W-1:0]  imm_i,
  output logic [DATA_W-1:0] ea_o
);
  assign ea_o = base_i + {{(DATA_W-IMM_W){imm_i[IMM_W-1]}}, imm_i};
endmodule

// File: rtl/mau_store_lanes.sv
module mau_store_lanes #(
  parameter int DATA_W = 32
) (
  input  logic [$clog2(DATA_W/8)-1:0] off_i,
  input  logic [1:0]                  size_i,
  input  logic [DATA_W-1:0]           wdata_i,
  output logic [DATA_W/8-1:0]         be_lo_o,
  output logic [DATA_W/8-1:0]         be_hi_o,
  output logic [DATA_W-1:0]           data_lo_o,
  output logic [DATA_W-1:0]           data_hi_o,
  output logic                        split_o
);
  localparam int NB = DATA_W / 8;

  logic [NB-1:0]       size_mask;
  logic [2*NB-1:0]     mask2;
  logic [2*DATA_W-1:0] data2;

  always_comb begin
    for (int i = 0; i < NB; i++) size_mask[i] = (i < (1 << int'(size_i)));
  end

  // two-word window: low half = first word, high half = next word
  assign mask2 = {{NB{1'b0}}, size_mask} << off_i;
  assign data2 = {{DATA_W{1'b0}}, wdata_i} << {off_i, 3'b000};

  assign be_lo_o   = mask2[NB-1:0];
  assign be_hi_o   = mask2[2*NB-1:NB];
  assign data_lo_o = data2[DATA_W-1:0];
  assign data_hi_o = data2[2*DATA_W-1:DATA_W];
  assign split_o   = |mask2[2*NB-1:NB];
endmodule

// File: rtl/mau_load_merge.sv
module mau_load_merge #(
  parameter int DATA_W = 32
) (
  input  logic [$clog2(DATA_W/8)-1:0] off_i,
  input  logic [1:0]                  size_i,
  input  logic                        unsigned_i,
  input  logic [DATA_W-1:0]           lo_i,
  input  logic [DATA_W-1:0]           hi_i,
  output logic [DATA_W-1:0]           data_o
);
  logic [2*DATA_W-1:0] win;
  logic [DATA_W-1:0]   raw;
  logic                sign;

  assign win = {hi_i, lo_i} >> {off_i, 3'b000};
  assign raw = win[DATA_W-1:0];

  always_comb begin
    sign = raw[DATA_W-1];
    for (int s = 0; (8 << s) < DATA_W; s++)
      if (int'(size_i) == s) sign = raw[(8 << s) - 1];
  end

  always_comb begin
    for (int i = 0; i < DATA_W; i++)
      data_o[i] = (i < (8 << int'(size_i))) ? raw[i] : (!unsigned_i && sign);
  end
endmodule

// File: rtl/mau_seq.sv
module mau_seq import mau_pkg::*; (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_valid_i,
  input  logic split_i,
  input  logic gnt_i,
  input  logic rvalid_i,
  output logic ready_o,
  output logic accept_o,
  output logic busy_o,
  output logic mem_req_o,
  output logic phase_o,
  output logic cap_lo_o,
  output logic final_o,
  output logic done_o
);
  seq_state_e state_q, state_d;
  logic       phase_q, phase_d;
  logic       done_q;

  always_comb begin
    state_d   = state_q;
    phase_d   = phase_q;
    accept_o  = 1'b0;
    mem_req_o = 1'b0;
    cap_lo_o  = 1'b0;
    final_o   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        accept_o = req_valid_i;
        if (req_valid_i) begin
          state_d = ST_ISSUE;
          phase_d = 1'b0;
        end
      end
      ST_ISSUE: begin
        mem_req_o = 1'b1;
        if (gnt_i) state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (rvalid_i) begin
          if (split_i && !phase_q) begin
            cap_lo_o = 1'b1;
            phase_d  = 1'b1;
            state_d  = ST_ISSUE;
          end else begin
            final_o = 1'b1;
            state_d = ST_IDLE;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      phase_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      phase_q <= phase_d;
      done_q  <= final_o;
    end
  end

  assign ready_o = (state_q == ST_IDLE);
  assign busy_o  = !ready_o;
  assign phase_o = phase_q;
  assign done_o  = done_q;
endmodule

// File: rtl/mem_align_unit.sv
module mem_align_unit import mau_pkg::*; #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 12
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  output logic                req_ready_o,
  input  logic                req_store_i,
  input  logic [1:0]          req_size_i,
  input  logic                req_unsigned_i,
  input  logic [DATA_W-1:0]   req_base_i,
  input  logic [IMM_W-1:0]    req_imm_i,
  input  logic [DATA_W-1:0]   req_wdata_i,
  output logic                busy_o,
  output logic                done_o,
  output logic [DATA_W-1:0]   load_data_o,
  output logic                mem_req_o,
  input  logic                mem_gnt_i,
  output logic [DATA_W-1:0]   mem_addr_o,
  output logic                mem_we_o,
  output logic [DATA_W/8-1:0] mem_be_o,
  output logic [DATA_W-1:0]   mem_wdata_o,
  input  logic                mem_rvalid_i,
  input  logic [DATA_W-1:0]   mem_rdata_i
);
  localparam int NB    = DATA_W / 8;
  localparam int OFF_W = $clog2(NB);

  logic [DATA_W-1:0] ea_d, ea_q, wdata_q, lo_q, rdata_q, merged;
  logic [1:0]        size_q;
  logic              store_q, uns_q;
  logic              accept, phase, cap_lo, fin, split;
  logic [NB-1:0]     be_lo, be_hi;
  logic [DATA_W-1:0] wd_lo, wd_hi;

  mau_agen #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_agen (
    .base_i (req_base_i),
    .imm_i  (req_imm_i),
    .ea_o   (ea_d)
  );

  mau_seq u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_valid_i(req_valid_i),
    .split_i   (split),
    .gnt_i     (mem_gnt_i),
    .rvalid_i  (mem_rvalid_i),
    .ready_o   (req_ready_o),
    .accept_o  (accept),
    .busy_o    (busy_o),
    .mem_req_o (mem_req_o),
    .phase_o   (phase),
    .cap_lo_o  (cap_lo),
    .final_o   (fin),
    .done_o    (done_o)
  );

  mau_store_lanes #(.DATA_W(DATA_W)) u_lanes (
    .off_i     (ea_q[OFF_W-1:0]),
    .size_i    (size_q),
    .wdata_i   (wdata_q),
    .be_lo_o   (be_lo),
    .be_hi_o   (be_hi),
    .data_lo_o (wd_lo),
    .data_hi_o (wd_hi),
    .split_o   (split)
  );

  mau_load_merge #(.DATA_W(DATA_W)) u_merge (
    .off_i      (ea_q[OFF_W-1:0]),
    .size_i     (size_q),
    .unsigned_i (uns_q),
    .lo_i       (split ? lo_q : mem_rdata_i),
    .hi_i       (split ? mem_rdata_i : '0),
    .data_o     (merged)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ea_q    <= '0;
      wdata_q <= '0;
      size_q  <= SZ_BYTE;
      store_q <= 1'b0;
      uns_q   <= 1'b0;
      lo_q    <= '0;
      rdata_q <= '0;
    end else begin
      if (accept) begin
        ea_q    <= ea_d;
        wdata_q <= req_wdata_i;
        size_q  <= req_size_i;
        store_q <= req_store_i;
        uns_q   <= req_unsigned_i;
      end
      if (cap_lo) lo_q <= mem_rdata_i;
      if (fin && !store_q) rdata_q <= merged;
    end
  end

  assign mem_addr_o  = {ea_q[DATA_W-1:OFF_W] + {{(DATA_W-OFF_W-1){1'b0}}, phase},
                        {OFF_W{1'b0}}};
  assign mem_we_o    = store_q;
  assign mem_be_o    = phase ? be_hi : be_lo;
  assign mem_wdata_o = phase ? wd_hi : wd_lo;
  assign load_data_o = rdata_q;
endmodule

// File: rtl/mau_chk.sv
module mau_chk #(
  parameter int DATA_W = 32
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                req_valid_i,
  input logic                busy_o,
  input logic                done_o,
  input logic                mem_req_o,
  input logic                mem_gnt_i,
  input logic [DATA_W-1:0]   mem_addr_o,
  input logic                mem_we_o,
  input logic [DATA_W/8-1:0] mem_be_o,
  input logic [DATA_W-1:0]   mem_wdata_o,
  input logic                mem_rvalid_i
);
  localparam int OFF_W = $clog2(DATA_W/8);

  logic pend_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else if (mem_req_o && mem_gnt_i) pend_q <= 1'b1;
    else if (mem_rvalid_i) pend_q <= 1'b0;
  end

  // R10
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_gnt_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_be_o)
                                && $stable(mem_we_o) && $stable(mem_wdata_o));
  // R10
  one_outstanding_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !pend_q);
  // R1
  addr_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> mem_addr_o[OFF_W-1:0] == '0);
  // R5
  be_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> mem_be_o != '0);
  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R9
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  // R8
  busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(req_valid_i));
  // R8
  req_in_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> busy_o);
endmodule

bind mem_align_unit mau_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .mem_req_o    (mem_req_o),
  .mem_gnt_i    (mem_gnt_i),
  .mem_addr_o   (mem_addr_o),
  .mem_we_o     (mem_we_o),
  .mem_be_o     (mem_be_o),
  .mem_wdata_o  (mem_wdata_o),
  .mem_rvalid_i (mem_rvalid_i)
);

// File: tb/mem_align_unit_tb.sv
module mem_align_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_store = 1'b0, req_uns = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic [31:0] req_base = '0, req_wdata = '0;
  logic [11:0] req_imm = '0;
  logic        req_ready, busy, done, mem_req, mem_we;
  logic [31:0] load_data, mem_addr, mem_wdata;
  logic [3:0]  mem_be;
  logic        mem_gnt = 1'b0, mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;

  always #4 clk = ~clk;

  mem_align_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_store_i(req_store),
    .req_size_i(req_size), .req_unsigned_i(req_uns), .req_base_i(req_base),
    .req_imm_i(req_imm), .req_wdata_i(req_wdata),
    .busy_o(busy), .done_o(done), .load_data_o(load_data),
    .mem_req_o(mem_req), .mem_gnt_i(mem_gnt), .mem_addr_o(mem_addr),
    .mem_we_o(mem_we), .mem_be_o(mem_be), .mem_wdata_o(mem_wdata),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata)
  );

  int vecs = 0, miss = 0;
  logic [7:0] ref_mem [64];
  logic [7:0] bmem [64];

  // model of the access in flight
  bit          cur_store, cur_uns;
  int          cur_size, cur_nb, cur_txn;
  logic [31:0] cur_ea, cur_wdata, exp_load;
  string       cur_lbl;

  bit          exp_busy = 0, exp_done = 0;
  int          txn_idx = 0, pend_cnt = 0, cyc = 0;
  logic [31:0] rd_hold = '0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (!ok) begin
      miss++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // per-cycle reference: handshake timing, memory responder, lane checks
  always @(negedge clk) begin
    bit acc, fin, allow;
    int lat, wrd, b;
    logic [3:0] ebe;
    if (rst_n) begin
      cyc++;
      chk(busy == exp_busy, "R8 busy", 32'(busy), 32'(exp_busy));
      chk(req_ready == !exp_busy, "R8 ready", 32'(req_ready), 32'(!exp_busy));
      chk(done == exp_done, "R9 done", 32'(done), 32'(exp_done));
      if (exp_done && !cur_store) chk(load_data == exp_load, cur_lbl, load_data, exp_load);
      acc = req_valid && req_ready;
      fin = 0;
      allow = (cyc % 5) != 2;
      lat = (cyc % 3 == 0) ? 2 : 1;
      mem_gnt = 1'b0;
      mem_rvalid = 1'b0;
      if (pend_cnt > 0) begin
        pend_cnt--;
        if (pend_cnt == 0) begin
          mem_rvalid = 1'b1;
          mem_rdata = rd_hold;
          fin = (txn_idx == cur_txn);
        end
      end else if (mem_req && allow) begin
        mem_gnt = 1'b1;
        chk(txn_idx < cur_txn, cur_txn == 2 ? "R6 txn count" : "R7 txn count", txn_idx, cur_txn);
        chk(mem_addr == (((cur_ea >> 2) + txn_idx) << 2), txn_idx == 0 ? "R1 addr" : "R6 addr",
            mem_addr, ((cur_ea >> 2) + txn_idx) << 2);
        chk(mem_we == cur_store, "R5 we", 32'(mem_we), 32'(cur_store));
        for (int k = 0; k < 4; k++) begin
          b = txn_idx * 4 + k - int'(cur_ea[1:0]);
          ebe[k] = (b >= 0) && (b < cur_nb);
          if (cur_store && ebe[k])
            chk(mem_wdata[8*k +: 8] == cur_wdata[8*b +: 8], "R2 store lane",
                32'(mem_wdata[8*k +: 8]), 32'(cur_wdata[8*b +: 8]));
        end
        if (cur_store) chk(mem_be == ebe, cur_txn == 2 ? "R6 be" : "R5 be", 32'(mem_be), 32'(ebe));
        wrd = int'(mem_addr[5:2]);
        for (int k = 0; k < 4; k++) begin
          rd_hold[8*k +: 8] = bmem[wrd*4+k];
          if (mem_we && mem_be[k]) bmem[wrd*4+k] = mem_wdata[8*k +: 8];
        end
        txn_idx++;
        pend_cnt = lat;
      end
      exp_done = fin;
      exp_busy = exp_busy ? !fin : acc;
      if (acc) txn_idx = 0;
    end
  end

  function automatic logic [31:0] extend(input logic [31:0] v, input int sz, input bit uns);
    if (sz == 0) return uns ? {24'b0, v[7:0]} : {{24{v[7]}}, v[7:0]};
    if (sz == 1) return uns ? {16'b0, v[15:0]} : {{16{v[15]}}, v[15:0]};
    return v;
  endfunction

  task automatic op(input bit st, input int sz, input bit uns, input logic [31:0] base,
                    input logic [11:0] imm, input logic [31:0] wd, input bit junk);
    logic [31:0] raw;
    @(posedge clk); #2;
    while (!req_ready) begin @(posedge clk); #2; end
    cur_store = st; cur_size = sz; cur_uns = uns; cur_wdata = wd;
    cur_nb = 1 << sz;
    cur_ea = base + {{20{imm[11]}}, imm};
    cur_txn = ((int'(cur_ea[1:0]) + cur_nb) > 4) ? 2 : 1;
    raw = '0;
    for (int i = 0; i < cur_nb; i++) begin
      if (st) ref_mem[(cur_ea + i) & 63] = wd[8*i +: 8];
      else raw[8*i +: 8] = ref_mem[(cur_ea + i) & 63];
    end
    exp_load = extend(raw, sz, uns);
    cur_lbl = (cur_txn == 2) ? "R6 load merge" : (sz == 2 || uns) ? "R4 load" : "R3 load";
    req_valid = 1'b1; req_store = st; req_size = 2'(sz); req_uns = uns;
    req_base = base; req_imm = imm; req_wdata = wd;
    @(posedge clk); #2;
    req_valid = 1'b0;
    if (junk) begin
      // R8: presented while busy, must not be taken
      req_valid = 1'b1; req_store = !st; req_base = ~base; req_imm = ~imm; req_size = 2'd2;
      @(posedge clk); #2;
      @(posedge clk); #2;
      req_valid = 1'b0;
    end
    while (!done) begin @(posedge clk); #2; end
    if (st)
      for (int i = 0; i < 64; i++)
        chk(bmem[i] == ref_mem[i], "R5 mem image", 32'(bmem[i]), 32'(ref_mem[i]));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miss++;
    $display("FAIL R9 watchdog act=0 exp=1");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) begin
      ref_mem[i] = 8'(i * 37 + 5);
      bmem[i] = 8'(i * 37 + 5);
    end
    repeat (3) @(posedge clk);
    #2;
    chk(!busy && !done && !mem_req && req_ready, "R8 reset", {busy, done, mem_req, req_ready}, 32'h1);
    rst_n = 1'b1;
    // loads, aligned and misaligned
    op(0, 2, 0, 32'h10, 12'h000, 0, 0);   // R7 word aligned
    op(0, 0, 0, 32'h13, 12'h000, 0, 0);   // R3 byte lane 3
    op(0, 0, 1, 32'h13, 12'h000, 0, 0);   // R4
    op(0, 1, 0, 32'h22, 12'h000, 0, 0);   // R3 half upper lanes
    op(0, 1, 1, 32'h23, 12'h000, 0, 0);   // R6 split half
    op(0, 2, 1, 32'h21, 12'h000, 0, 0);   // R6 word off 1
    op(0, 2, 0, 32'h22, 12'h000, 0, 1);   // R6 + R8 junk
    op(0, 2, 0, 32'h43, 12'hFFC, 0, 0);   // R1 negative offset
    // stores
    op(1, 0, 0, 32'h08, 12'h001, 32'hA5A5_A581, 0); // R5 byte lane 1
    op(1, 1, 0, 32'h0B, 12'h000, 32'h0000_C3D2, 1); // R6 split half
    op(1, 2, 0, 32'h1E, 12'h000, 32'h8765_4321, 0); // R6 split word
    op(1, 2, 0, 32'h30, 12'h000, 32'hDEAD_BEEF, 0); // R7 aligned
    op(0, 0, 0, 32'h0B, 12'h000, 0, 0);   // R2 read back
    op(0, 2, 0, 32'h1E, 12'h000, 0, 0);   // R2 read back split
    op(0, 1, 0, 32'h3F, 12'h000, 0, 0);   // wrap to word 0 in bench memory
    for (int n = 0; n < 400; n++)
      op(bit'($urandom % 2), int'($urandom % 3), bit'($urandom % 2), $urandom,
         12'($urandom), $urandom, bit'((n % 7) == 0));
    repeat (4) @(posedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end
endmodule